// File: doc/BRIEF.md
# Pseudo-Mersenne Word-Serial Modular Reducer

This block takes a double-length product held in a word-addressed buffer and reduces it modulo a prime of the form p = 2^n − c. The operand length m (in 16-bit words) and the small constant c are supplied with each start, so one instance serves several field sizes. The bit length is n = 16m − 1, and c is at most 15 bits wide. The block reads the 2m product words through a synchronous read port and writes an m-word result through a write port. It then raises a one-cycle done pulse.

The reduction uses two word-aligned folds through one multiply-accumulate unit. The first fold multiplies the upper m words by 2c and adds them into the lower m words. This gives an intermediate value of m+1 words. The second fold takes the 17 bits above position n, multiplies them by c and adds the product into the low n bits. The carry then ripples up to the top word. Neither fold shifts the upper half by a bit. The result is congruent to the input but may still exceed p. A later stage performs the final conditional subtraction. The cycle count depends only on m.

Top module: `pmr_reducer`

## Requirements
- R1: After reset, `busy`, `done`, `prod_rd_en` and `res_wr_en` are all low.
- R2: After a start, the block reads each product word exactly once. The reads come in pairs, for i from 0 upward: low word i, then high word m+i. No address at or above 2m is read.
- R3: For m from 3 to MAX_WORDS and c from 1 to 2^15−1, the written result r satisfies r mod p = z mod p.
- R4: The result is below 2^n + 2^32. It always fits in m words.
- R5: Each run writes exactly m result words, one per cycle, at addresses 0 to m−1 in ascending order. Word 0 is the least significant.
- R6: `done` is a one-cycle pulse. It rises exactly 3m+2 clock edges after the edge that accepts start, whatever the product data.
- R7: While `busy` is high, `start` has no effect. Changes on `m_words` or `c_val` during that time also have no effect. The running reduction keeps its latency and its result.
- R8: `busy` is high from the edge that accepts start until the cycle in which `done` is high. In that cycle `busy` is low.
- R9: No intermediate carry is lost when every product word is 0xFFFF and c = 2^15−1. The first-fold top carry fits 16 bits, and the second fold leaves no carry out of word m−1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a reduction; accepted only while idle |
| m_words | input | 5 | Operand length m in words (3 to MAX_WORDS), captured at start |
| c_val | input | 15 | Modulus constant c, captured at start |
| prod_rd_en | output | 1 | Product buffer read strobe |
| prod_rd_addr | output | 5 | Product buffer word address |
| prod_rd_data | input | 16 | Product word, valid the cycle after the strobe |
| res_wr_en | output | 1 | Result write strobe |
| res_wr_addr | output | 4 | Result word address |
| res_wr_data | output | 16 | Result word |
| busy | output | 1 | Reduction in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
A corrupted carry or a wrong low-word latch in the first fold changes the result by a multiple of 2^16 that is not a multiple of p. The congruence check then fails at the done pulse, about 3m cycles after start. A sequencing fault shows up earlier, at the ports: a read counter off by one breaks the read order or the 3m+2 latency, and a wrong second-fold index breaks the ascending write addresses. A mistake in splitting t at bit n either breaks congruence or pushes the result past the 2^n + 2^32 bound. The all-ones product with the largest c exercises the widest carries.

// File: rtl/pmr_pkg.sv
package pmr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FOLD1 = 2'd1,
        ST_PREP  = 2'd2,
        ST_FOLD2 = 2'd3
    } pmr_state_e;

endpackage

// File: rtl/pmr_mac.sv
// Multiply-accumulate: acc_out = mul_a * mul_b + add_x + add_y
module pmr_mac #(
    parameter int unsigned A_W = 17,
    parameter int unsigned B_W = 16,
    parameter int unsigned S_W = 34
) (
    input  logic [A_W-1:0] mul_a,
    input  logic [B_W-1:0] mul_b,
    input  logic [S_W-1:0] add_x,
    input  logic [S_W-1:0] add_y,
    output logic [S_W-1:0] acc_out
);

    always_comb begin
        acc_out = S_W'(mul_a) * S_W'(mul_b) + add_x + add_y;
    end

endmodule

// File: rtl/pmr_tstore.sv
// Register file for the low m words of the intermediate value
module pmr_tstore #(
    parameter int unsigned WORD_W = 16,
    parameter int unsigned DEPTH  = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  logic [$clog2(DEPTH)-1:0]  waddr,
    input  logic [WORD_W-1:0]         wdata,
    input  logic [$clog2(DEPTH)-1:0]  raddr,
    output logic [WORD_W-1:0]         rdata
);

    localparam int unsigned AW = $clog2(DEPTH);

    logic [DEPTH-1:0][WORD_W-1:0] word_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
        end else begin
            for (int unsigned g = 0; g < DEPTH; g++) begin
                if (we && (waddr == AW'(g))) begin
                    word_q[g] <= wdata;
                end
            end
        end
    end

    assign rdata = word_q[raddr];

endmodule

// File: rtl/pmr_reducer.sv
module pmr_reducer #(
    parameter int unsigned WORD_W    = 16,
    parameter int unsigned MAX_WORDS = 16
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                start,
    input  logic [$clog2(MAX_WORDS+1)-1:0]      m_words,
    input  logic [WORD_W-2:0]                   c_val,
    output logic                                prod_rd_en,
    output logic [$clog2(2*MAX_WORDS)-1:0]      prod_rd_addr,
    input  logic [WORD_W-1:0]                   prod_rd_data,
    output logic                                res_wr_en,
    output logic [$clog2(MAX_WORDS)-1:0]        res_wr_addr,
    output logic [WORD_W-1:0]                   res_wr_data,
    output logic                                busy,
    output logic                                done
);

    import pmr_pkg::*;

    localparam int unsigned MW   = $clog2(MAX_WORDS + 1);
    localparam int unsigned K_W  = MW + 1;
    localparam int unsigned PA_W = $clog2(2 * MAX_WORDS);
    localparam int unsigned RA_W = $clog2(MAX_WORDS);
    localparam int unsigned A_W  = WORD_W + 1;
    localparam int unsigned S_W  = 2 * WORD_W + 2;

    typedef struct packed {
        pmr_state_e           st;
        logic [K_W-1:0]       k;      // fold-1 step or fold-2 word index
        logic [MW-1:0]        m;
        logic [WORD_W-2:0]    c;
        logic [WORD_W-1:0]    lo;     // latched low product word
        logic [WORD_W:0]      carry;  // running carry, top word of t after fold 1
        logic [2*WORD_W:0]    prod;   // tH * c
        logic                 done;
    } regs_t;

    regs_t q, d;

    logic              tst_we;
    logic [RA_W-1:0]   tst_waddr;
    logic [RA_W-1:0]   tst_raddr;
    logic [WORD_W-1:0] tst_wdata;
    logic [WORD_W-1:0] tst_rdata;

    logic [A_W-1:0]    mac_a;
    logic [WORD_W-1:0] mac_b;
    logic [S_W-1:0]    mac_x;
    logic [S_W-1:0]    mac_y;
    logic [S_W-1:0]    mac_sum;

    logic [K_W-1:0]    m_ext;
    logic [K_W-1:0]    two_m;
    logic [K_W-1:0]    kp;
    logic              last_word;
    logic [WORD_W-1:0] tl_word;
    logic [WORD_W-1:0] pw_word;
    logic [WORD_W:0]   f2_sum;

    assign m_ext     = K_W'(q.m);
    assign two_m     = {q.m, 1'b0};
    assign kp        = q.k - K_W'(1);
    assign last_word = (q.k == (m_ext - K_W'(1)));
    assign tst_raddr = (q.st == ST_PREP) ? RA_W'(m_ext - K_W'(1)) : RA_W'(q.k);

    pmr_tstore #(
        .WORD_W (WORD_W),
        .DEPTH  (MAX_WORDS)
    ) u_tstore (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (tst_we),
        .waddr (tst_waddr),
        .wdata (tst_wdata),
        .raddr (tst_raddr),
        .rdata (tst_rdata)
    );

    pmr_mac #(
        .A_W (A_W),
        .B_W (WORD_W),
        .S_W (S_W)
    ) u_mac (
        .mul_a   (mac_a),
        .mul_b   (mac_b),
        .add_x   (mac_x),
        .add_y   (mac_y),
        .acc_out (mac_sum)
    );

    // Operand selection for the shared multiply-accumulate unit
    always_comb begin
        mac_a = '0;
        mac_b = '0;
        mac_x = '0;
        mac_y = '0;
        if (q.st == ST_FOLD1) begin
            mac_a = {1'b0, prod_rd_data};
            mac_b = {q.c, 1'b0};
            mac_x = S_W'(q.lo);
            mac_y = S_W'(q.carry);
        end else if (q.st == ST_PREP) begin
            mac_a = {q.carry[WORD_W-1:0], tst_rdata[WORD_W-1]};
            mac_b = {1'b0, q.c};
        end
    end

    // Next-state computation
    always_comb begin
        d      = q;
        d.done = 1'b0;

        tst_we    = 1'b0;
        tst_waddr = RA_W'(kp >> 1);
        tst_wdata = mac_sum[WORD_W-1:0];

        prod_rd_en   = 1'b0;
        prod_rd_addr = PA_W'(q.k[0] ? (m_ext + (q.k >> 1)) : (q.k >> 1));

        tl_word = tst_rdata;
        if (last_word) begin
            tl_word[WORD_W-1] = 1'b0;
        end
        if (q.k == K_W'(0)) begin
            pw_word = q.prod[WORD_W-1:0];
        end else if (q.k == K_W'(1)) begin
            pw_word = q.prod[2*WORD_W-1:WORD_W];
        end else begin
            pw_word = '0;
        end
        f2_sum = {1'b0, tl_word} + {1'b0, pw_word} + (WORD_W+1)'(q.carry[0]);

        res_wr_en   = 1'b0;
        res_wr_addr = RA_W'(q.k);
        res_wr_data = f2_sum[WORD_W-1:0];

        unique case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.st    = ST_FOLD1;
                    d.k     = '0;
                    d.m     = m_words;
                    d.c     = c_val;
                    d.carry = '0;
                    d.lo    = '0;
                end
            end
            ST_FOLD1: begin
                prod_rd_en = (q.k < two_m);
                if (q.k != K_W'(0)) begin
                    if (!kp[0]) begin
                        d.lo = prod_rd_data;
                    end else begin
                        tst_we  = 1'b1;
                        d.carry = mac_sum[2*WORD_W:WORD_W];
                    end
                end
                if (q.k == two_m) begin
                    d.st = ST_PREP;
                    d.k  = '0;
                end else begin
                    d.k = q.k + K_W'(1);
                end
            end
            ST_PREP: begin
                d.prod  = mac_sum[2*WORD_W:0];
                d.carry = '0;
                d.k     = '0;
                d.st    = ST_FOLD2;
            end
            ST_FOLD2: begin
                res_wr_en = 1'b1;
                d.carry   = (WORD_W+1)'(f2_sum[WORD_W]);
                if (last_word) begin
                    d.st   = ST_IDLE;
                    d.k    = '0;
                    d.done = 1'b1;
                end else begin
                    d.k = q.k + K_W'(1);
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign busy = (q.st != ST_IDLE);
    assign done = q.done;

    // R9
    fold1_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_PREP) |-> (q.carry[WORD_W] == 1'b0));

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_FOLD2 && last_word) |-> (f2_sum[WORD_W] == 1'b0 && q.prod[2*WORD_W] == 1'b0));

    // R9
    mac_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mac_sum[S_W-1] == 1'b0);

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5
    wr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_wr_en && $past(res_wr_en)) |-> (res_wr_addr == $past(res_wr_addr) + RA_W'(1)));

    // R2
    rd_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prod_rd_en |-> (K_W'(prod_rd_addr) < two_m));

    // R8
    rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(prod_rd_en && res_wr_en));

endmodule

// File: tb/pmr_reducer_test.sv
`timescale 1ns/1ps
module pmr_reducer_test;

    localparam int MAXW = 16;
    localparam int BW   = 32 * MAXW;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [4:0]  m_in = 5'd3;
    logic [14:0] c_in = 15'd1;
    logic        rd_en;
    logic [4:0]  rd_addr;
    logic [15:0] rd_data = '0;
    logic        wr_en;
    logic [3:0]  wr_addr;
    logic [15:0] wr_data;
    logic        busy;
    logic        done;

    int total = 0;
    int fails = 0;

    logic [15:0] mem [0:2*MAXW-1];
    logic [15:0] res [0:MAXW-1];
    int          rd_log [0:2*MAXW-1];
    int          wr_log [0:MAXW-1];
    int          rd_cnt = 0;
    int          wr_cnt = 0;
    logic        log_clr = 1'b0;

    always #2 clk = ~clk;

    pmr_reducer uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .m_words      (m_in),
        .c_val        (c_in),
        .prod_rd_en   (rd_en),
        .prod_rd_addr (rd_addr),
        .prod_rd_data (rd_data),
        .res_wr_en    (wr_en),
        .res_wr_addr  (wr_addr),
        .res_wr_data  (wr_data),
        .busy         (busy),
        .done         (done)
    );

    // Buffer models and port logging
    always @(posedge clk) begin
        if (rd_en) rd_data <= mem[rd_addr];
        if (wr_en) res[wr_addr] <= wr_data;
        if (log_clr) begin
            rd_cnt <= 0;
            wr_cnt <= 0;
        end else begin
            if (rd_en) begin
                if (rd_cnt < 2*MAXW) rd_log[rd_cnt] <= int'(rd_addr);
                rd_cnt <= rd_cnt + 1;
            end
            if (wr_en) begin
                if (wr_cnt < MAXW) wr_log[wr_cnt] <= int'(wr_addr);
                wr_cnt <= wr_cnt + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string tag,
                       input logic [BW-1:0] act, input logic [BW-1:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
    endtask

    function automatic logic [BW-1:0] prod_value(int m);
        logic [BW-1:0] v = '0;
        for (int i = 2*m - 1; i >= 0; i--) v = (v << 16) | BW'(mem[i]);
        return v;
    endfunction

    function automatic logic [BW-1:0] res_value(int m);
        logic [BW-1:0] v = '0;
        for (int i = m - 1; i >= 0; i--) v = (v << 16) | BW'(res[i]);
        return v;
    endfunction

    task automatic fill(int m, int pat);
        for (int i = 0; i < 2*MAXW; i++) begin
            if (i >= 2*m) mem[i] = 16'($urandom);
            else case (pat)
                0: mem[i] = 16'($urandom);
                1: mem[i] = 16'hFFFF;
                2: mem[i] = 16'h0000;
                3: mem[i] = (i >= m) ? 16'hFFFF : 16'h0000;
                default: mem[i] = i[0] ? 16'hAAAA : 16'h5555;
            endcase
        end
    endtask

    task automatic run_case(int m, logic [14:0] c, bit intr);
        int cyc = 0;
        bit seen = 0;
        bit busy_ok = 1;
        bit busy_at_done = 0;
        bit ord_ok;
        logic [BW-1:0] z, r, p;
        string id;
        id = $sformatf("m=%0d c=%0d", m, c);
        @(negedge clk); log_clr = 1'b1;
        @(negedge clk); log_clr = 1'b0;
        m_in = 5'(m); c_in = c; start = 1'b1;
        @(negedge clk); start = 1'b0;
        while (!seen && cyc < 400) begin
            @(negedge clk);
            cyc++;
            if (intr && cyc == 4) begin
                start = 1'b1;
                m_in  = (m == 3) ? 5'd4 : 5'd3;
                c_in  = ~c;
            end
            if (intr && cyc == 5) start = 1'b0;
            if (done) begin
                seen = 1;
                busy_at_done = busy;
            end else if (!busy) busy_ok = 0;
        end
        // R6: latency 3m+2 regardless of data
        chk(seen && cyc == 3*m + 2, {"R6 latency ", id}, BW'(cyc), BW'(3*m + 2));
        // R8: busy over the run, low with done
        chk(busy_ok && !busy_at_done, {"R8 busy ", id}, BW'({busy_ok, busy_at_done}), BW'(2'b10));
        @(negedge clk);
        // R6: single-cycle pulse
        chk(!done, {"R6 pulse ", id}, BW'(done), BW'(0));
        repeat (3) @(negedge clk);
        // R2: read order low i, high m+i
        ord_ok = (rd_cnt == 2*m);
        for (int i = 0; i < m && ord_ok; i++) begin
            if (rd_log[2*i] != i || rd_log[2*i+1] != m + i) ord_ok = 0;
        end
        chk(ord_ok, {"R2 read order ", id}, BW'(rd_cnt), BW'(2*m));
        // R5 and R7: exactly m ascending writes, no second run
        ord_ok = (wr_cnt == m);
        for (int j = 0; j < m && ord_ok; j++) if (wr_log[j] != j) ord_ok = 0;
        chk(ord_ok, {intr ? "R7 R5 writes " : "R5 writes ", id}, BW'(wr_cnt), BW'(m));
        z = prod_value(m);
        r = res_value(m);
        p = (BW'(1) << (16*m - 1)) - BW'(c);
        // R3 (R7 when interrupted, R9 on all-ones with max c)
        chk((r % p) == (z % p), {intr ? "R7 R3 congruence " : "R3 R9 congruence ", id}, r % p, z % p);
        // R4: bound
        chk(r < ((BW'(1) << (16*m - 1)) + (BW'(1) << 32)), {"R4 bound ", id}, r,
            (BW'(1) << (16*m - 1)) + (BW'(1) << 32));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        total++;
        $display("FAIL watchdog R6: actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        logic [14:0] cv;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!busy && !done && !rd_en && !wr_en, "R1 reset",
            BW'({busy, done, rd_en, wr_en}), BW'(0));
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !rd_en && !wr_en, "R1 idle after reset",
            BW'({busy, done, rd_en, wr_en}), BW'(0));
        for (int m = 3; m <= MAXW; m++) begin
            for (int pat = 0; pat < 5; pat++) begin
                for (int ci = 0; ci < 3; ci++) begin
                    cv = (ci == 0) ? 15'd1 : (ci == 1) ? 15'(($urandom % 32766) + 1) : 15'h7FFF;
                    fill(m, pat);
                    run_case(m, cv, (pat == 0 && ci == 1));
                end
            end
        end
        summary();
        $finish;
    end

endmodule